// File: doc/BRIEF.md
# Condition code evaluator

This block turns four arithmetic status flags (zero, carry, sign, overflow) and a 4-bit condition code into one true/false answer. Conditional branches, set-byte operations and conditional moves all consume that answer. A conditional move copies its source only when the answer is true and leaves the destination alone otherwise. A set-byte operation writes the answer as the byte value 1 or 0, so the block also presents it widened to a byte.

The block is purely combinational and holds no state. There are twelve conditions. Each pair of neighbouring codes (an even code and the odd code after it) forms a condition and its logical opposite. The four codes above the last condition answer false. Four named stages make up the data path. The term stage evaluates every condition in parallel from the flags. The pick stage chooses the term that the code addresses. The widen stage builds the byte result. The top stage connects the three and carries the cross-checks.

Top module: `ccode_judge`

## Requirements
- R1: Code 0 (equal) is true when the zero flag is set; code 1 (not equal) is true when it is clear.
- R2: Code 2 (negative) is true when the sign flag is set; code 3 (not negative) is true when it is clear.
- R3: Code 4 (signed greater) is true when sign equals overflow and zero is clear; code 5 (signed less-or-equal) is true when sign differs from overflow or zero is set.
- R4: Code 6 (signed greater-or-equal) is true when sign equals overflow; code 7 (signed less) is true when they differ.
- R5: Code 8 (unsigned above) is true when carry and zero are both clear; code 9 (unsigned below-or-equal) is true when carry or zero is set.
- R6: Code 10 (unsigned above-or-equal) is true when carry is clear; code 11 (unsigned below) is true when carry is set.
- R7: Codes 12 to 15 give false for every flag combination.
- R8: `hit_byte` equals 1 when `cond_hit` is 1 and 0 otherwise; bits 7 down to 1 are always 0.
- R9: For any flags, codes 2k and 2k+1 (k = 0..5) give opposite results.
- R10: The result depends only on the present inputs: the same flags and code give the same result whatever was applied before, and there is no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| cond_sel | input | 4 | Condition code, 0 to 15 |
| cond_hit | output | 1 | Selected condition holds |
| hit_byte | output | 8 | Result as a byte, value 1 or 0 |

## Verification
The bench builds the block with its default parameters: a 4-bit code and an 8-bit byte result. This selector width covers all sixteen codes, including the four unused ones. With four flags, every flag pattern against every code is only 256 cases, so the bench applies all of them. It first sweeps with the code in the inner loop, which places each pair of opposite codes on adjacent cycles. It then sweeps again in a different order, so that each case follows a different history.

// File: rtl/ccode_pkg.sv
package ccode_pkg;

    localparam int NUM_COND = 12;

    typedef enum logic [3:0] {
        CC_EQ   = 4'd0,
        CC_NE   = 4'd1,
        CC_NEG  = 4'd2,
        CC_NNEG = 4'd3,
        CC_GT   = 4'd4,
        CC_LE   = 4'd5,
        CC_GE   = 4'd6,
        CC_LT   = 4'd7,
        CC_AB   = 4'd8,
        CC_BE   = 4'd9,
        CC_AE   = 4'd10,
        CC_BL   = 4'd11
    } cc_code_e;

endpackage

// File: rtl/ccode_terms.sv
module ccode_terms
    import ccode_pkg::*;
(
    input  logic                fz,
    input  logic                fc,
    input  logic                fs,
    input  logic                fo,
    output logic [NUM_COND-1:0] terms
);

    always_comb begin
        terms          = '0;
        terms[CC_EQ]   = fz;
        terms[CC_NE]   = ~fz;
        terms[CC_NEG]  = fs;
        terms[CC_NNEG] = ~fs;
        terms[CC_GT]   = (fs ~^ fo) & ~fz;
        terms[CC_LE]   = (fs ^ fo) | fz;
        terms[CC_GE]   = fs ~^ fo;
        terms[CC_LT]   = fs ^ fo;
        terms[CC_AB]   = ~fc & ~fz;
        terms[CC_BE]   = fc | fz;
        terms[CC_AE]   = ~fc;
        terms[CC_BL]   = fc;
    end

endmodule

// File: rtl/ccode_pick.sv
module ccode_pick #(
    parameter int SEL_W = 4,
    parameter int N     = 12
) (
    input  logic [N-1:0]     terms,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (sel == SEL_W'(k)) hit = terms[k];
        end
    end

endmodule

// File: rtl/ccode_widen.sv
module ccode_widen #(
    parameter int BYTE_W = 8
) (
    input  logic              hit,
    output logic [BYTE_W-1:0] wide
);

    assign wide[0] = hit;

    generate
        for (genvar b = 1; b < BYTE_W; b++) begin : g_pad
            assign wide[b] = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ccode_judge.sv
module ccode_judge
    import ccode_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int BYTE_W = 8
) (
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_s,
    input  logic              flag_o,
    input  logic [SEL_W-1:0]  cond_sel,
    output logic              cond_hit,
    output logic [BYTE_W-1:0] hit_byte
);

    localparam int PAIRS = NUM_COND / 2;

    logic [NUM_COND-1:0] cond_vec;

    ccode_terms u_terms (
        .fz    (flag_z),
        .fc    (flag_c),
        .fs    (flag_s),
        .fo    (flag_o),
        .terms (cond_vec)
    );

    ccode_pick #(.SEL_W(SEL_W), .N(NUM_COND)) u_pick (
        .terms (cond_vec),
        .sel   (cond_sel),
        .hit   (cond_hit)
    );

    ccode_widen #(.BYTE_W(BYTE_W)) u_widen (
        .hit  (cond_hit),
        .wide (hit_byte)
    );

    // Cross-checks between the term, pick and widen stages.
    always_comb begin
        for (int k = 0; k < PAIRS; k++) begin
            assert_pair_opposite_R9: assert (cond_vec[2*k] != cond_vec[2*k+1]);
        end
        assert_signed_order_R3: assert (!cond_vec[CC_GT] || cond_vec[CC_GE]);
        assert_unsigned_order_R5: assert (!cond_vec[CC_AB] || cond_vec[CC_AE]);
        assert_unused_false_R7: assert (int'(cond_sel) < NUM_COND || !cond_hit);
        for (int k = 0; k < NUM_COND; k++) begin
            if (cond_sel == SEL_W'(k)) begin
                assert_byte_match_R8: assert (hit_byte == BYTE_W'(cond_vec[k]));
            end
        end
    end

endmodule

// File: tb/test_ccode_judge.sv
module test_ccode_judge;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fz = 1'b0, fc = 1'b0, fs = 1'b0, fo = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       hit;
    logic [7:0] hbyte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit prev_hit = 1'b0;

    always #5 clk = ~clk;

    ccode_judge i_ccode_judge (
        .flag_z   (fz),
        .flag_c   (fc),
        .flag_s   (fs),
        .flag_o   (fo),
        .cond_sel (sel),
        .cond_hit (hit),
        .hit_byte (hbyte)
    );

    function automatic bit ref_eval(int code, bit z, bit c, bit s, bit o);
        bit lt = (s != o);
        case (code)
            0:  return z;
            1:  return !z;
            2:  return s;
            3:  return !s;
            4:  return !lt && !z;
            5:  return lt || z;
            6:  return !lt;
            7:  return lt;
            8:  return !c && !z;
            9:  return c || z;
            10: return !c;
            11: return c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int code);
        case (code)
            0, 1:   return "R1";
            2, 3:   return "R2";
            4, 5:   return "R3";
            6, 7:   return "R4";
            8, 9:   return "R5";
            10, 11: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b (sel=%0d z=%0b c=%0b s=%0b o=%0b)",
                     tag, act, exp, sel, fz, fc, fs, fo);
        end
    endtask

    task automatic check_byte(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h (sel=%0d)", tag, act, exp, sel);
        end
    endtask

    // Apply one case on the falling edge, compare just after the rising edge.
    task automatic apply(int code, int f, string extra);
        bit e;
        @(negedge clk);
        sel = 4'(code);
        fz = f[0]; fc = f[1]; fs = f[2]; fo = f[3];
        @(posedge clk);
        #1;
        e = ref_eval(code, f[0], f[1], f[2], f[3]);
        check_bit(extra == "" ? tag_of(code) : extra, hit, e);
        check_byte("R8", hbyte, {7'b0, e});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Reset-time state: all flags clear, code 0 gives false.
        check_bit("R1", hit, 1'b0);
        check_byte("R8", hbyte, 8'h00);

        // Sweep 1: code inner, pairs on adjacent cycles.
        for (int f = 0; f < 16; f++) begin
            for (int code = 0; code < 16; code++) begin
                apply(code, f, "");
                if (code < 12 && code[0]) check_bit("R9", hit, !prev_hit);
                prev_hit = hit;
            end
        end

        // Sweep 2: reversed order, different history for every case.
        for (int code = 15; code >= 0; code--) begin
            for (int f = 15; f >= 0; f--) begin
                apply(code, f, "R10");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule